// File: doc/BRIEF.md
# Byte-Addressed Serial EEPROM Target

This block is the bus-facing half of a small serial EEPROM: a two-wire (I2C) target in front of a 256-byte array built from flops. The bus pins are a clock input and an open-drain data line. The data line is modelled as an input plus an output enable that pulls the line low. START and STOP are recovered from synchronized copies of both pins. A controller can write one byte per frame or read any number of consecutive bytes. Every completed write is followed by a self-timed programming window, and during that window the device does not answer the bus at all.

The controller addresses the device with the fixed family nibble 1010, three configuration bits set by the `DEV_CFG` parameter, and a direction bit. A write frame carries a word address and then one data byte. A read frame streams bytes from an internal pointer until the controller declines a byte.

Control is one state machine:
- `ST_IDLE` waits for START.
- `ST_DEVADDR` shifts in the address byte. A match goes to `ST_DEV_ACK`; a mismatch goes back to `ST_IDLE`.
- From `ST_DEV_ACK` the direction bit selects the next state. A write goes through `ST_WADDR` → `ST_WADDR_ACK` → `ST_WDATA` → `ST_WDATA_ACK` → `ST_WAIT_STOP`.
- A read alternates `ST_RD_BYTE` ↔ `ST_RD_ACK`. A controller NACK in `ST_RD_ACK` leads to `ST_WAIT_STOP`.
- STOP in `ST_WAIT_STOP` with a byte pending goes to `ST_PROG`. `ST_PROG` returns to `ST_IDLE` when the busy timer runs out.
- Outside `ST_PROG`, any START leads to `ST_DEVADDR` and any other STOP leads to `ST_IDLE`.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset the data line is released (`sda_oe` = 0), every array byte reads 0x00 and the read pointer is 0.
- R2: After a START, the address byte {1010, DEV_CFG, rw} is acknowledged by driving the data line low through the ninth clock. Any other address gets no acknowledge, and the device stays released until the next START.
- R3: In a write frame (rw = 0), the device acknowledges the word-address byte and the data byte. The data byte is stored at that word address when the STOP that ends the frame arrives.
- R4: In a read frame (rw = 1), bytes leave MSB first, starting at the pointer. The pointer advances by one after each byte and wraps from 255 to 0. A word address sent in a write frame and followed by a repeated START sets the pointer for the read. A read without a word address continues from the pointer.
- R5: When the controller leaves the data line high on the ninth clock of a read byte, the device stops driving and ignores further clocks until STOP or START.
- R6: For BUSY_CYCLES system clocks after a write's STOP, no START, address or byte is acknowledged. After that window the device answers again.
- R7: A write frame that ends with STOP right after the word address sets the pointer and starts no programming window.
- R8: The device changes the data line only while the clock line is low, and samples incoming bits on the rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The data-line hold check assumes the clock line stays low for more than four system clocks after each falling edge, which gives the synchronizer time to pass the edge through. It also assumes that the controller issues START and STOP only while the device has released the line. The bench keeps every bus phase twelve system clocks long and changes the data line only in the middle of the clock-low phase, so both assumptions hold. The busy-window checks assume a frame takes longer to reach the address acknowledge than zero cycles and shorter than BUSY_CYCLES, and the bench parameter is chosen so that this holds.

// File: rtl/eep_pkg.sv
package eep_pkg;
    localparam logic [3:0] DEV_FAMILY = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_WAIT_STOP,
        ST_PROG
    } eep_state_e;
endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int DEPTH = (STAGES < 2) ? 2 : STAGES;

    logic [DEPTH-1:0] scl_pipe, sda_pipe;
    logic             scl_s, scl_d, sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[DEPTH-2:0], scl_i};
            sda_pipe <= {sda_pipe[DEPTH-2:0], sda_i};
            scl_d    <= scl_s;
            sda_d    <= sda_s;
        end
    end

    assign scl_s     = scl_pipe[DEPTH-1];
    assign sda_s     = sda_pipe[DEPTH-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/eep_mem.sv
module eep_mem #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/eep_busy_timer.sv
module eep_busy_timer #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              remain <= '0;
        else if (start)          remain <= CW'(CYCLES);
        else if (remain != '0)   remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
    import eep_pkg::*;
#(
    parameter logic [2:0] DEV_CFG     = 3'b000,
    parameter int         BUSY_CYCLES = 5000,
    parameter int         SYNC_STAGES = 2,
    parameter int         AW          = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    localparam int DW       = 8;
    localparam int BCW      = $clog2(DW + 1);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(DW);
    localparam logic [6:0] MY_ADDR = {DEV_FAMILY, DEV_CFG};

    eep_state_e state_q, state_d;

    logic          sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [DW-1:0] shreg, wdata_q, mem_rdata;
    logic [AW-1:0] ptr;
    logic [BCW-1:0] bitcnt;
    logic          ack_rise, m_ack, wr_pend;
    logic          mem_we, tmr_busy;
    logic          byte_done, rx_state, ack_state;

    eep_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    eep_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(ptr),
        .wdata(wdata_q), .raddr(ptr), .rdata(mem_rdata)
    );

    eep_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(mem_we), .busy(tmr_busy)
    );

    assign byte_done = scl_fall && (bitcnt == LAST_BIT);
    assign rx_state  = (state_q == ST_DEVADDR) || (state_q == ST_WADDR) ||
                       (state_q == ST_WDATA);
    assign ack_state = (state_q == ST_DEV_ACK) || (state_q == ST_WADDR_ACK) ||
                       (state_q == ST_WDATA_ACK) || (state_q == ST_RD_ACK);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (state_q == ST_PROG) begin
            if (!tmr_busy) state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_DEVADDR;
        end else if (stop_det) begin
            state_d = (state_q == ST_WAIT_STOP && wr_pend) ? ST_PROG : ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_DEVADDR:   if (byte_done)
                                  state_d = (shreg[7:1] == MY_ADDR) ? ST_DEV_ACK : ST_IDLE;
                ST_DEV_ACK:   if (scl_fall && ack_rise)
                                  state_d = shreg[0] ? ST_RD_BYTE : ST_WADDR;
                ST_WADDR:     if (byte_done) state_d = ST_WADDR_ACK;
                ST_WADDR_ACK: if (scl_fall && ack_rise) state_d = ST_WDATA;
                ST_WDATA:     if (byte_done) state_d = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall && ack_rise) state_d = ST_WAIT_STOP;
                ST_RD_BYTE:   if (byte_done) state_d = ST_RD_ACK;
                ST_RD_ACK:    if (scl_fall && ack_rise)
                                  state_d = m_ack ? ST_RD_BYTE : ST_WAIT_STOP;
                ST_WAIT_STOP: state_d = ST_WAIT_STOP;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            wdata_q  <= '0;
            ptr      <= '0;
            bitcnt   <= '0;
            ack_rise <= 1'b0;
            m_ack    <= 1'b0;
            wr_pend  <= 1'b0;
        end else if (state_q != ST_PROG && start_det) begin
            bitcnt   <= '0;
            ack_rise <= 1'b0;
            wr_pend  <= 1'b0;
        end else if (state_q != state_d) begin
            bitcnt   <= '0;
            ack_rise <= 1'b0;
            if (state_d == ST_WADDR_ACK) ptr <= shreg;
            if (state_d == ST_WDATA_ACK) begin
                wdata_q <= shreg;
                wr_pend <= 1'b1;
            end
            if (state_d == ST_RD_BYTE) shreg <= mem_rdata;
            if (state_d == ST_RD_ACK)  ptr   <= ptr + 1'b1;
            if (state_d == ST_PROG || state_d == ST_IDLE) wr_pend <= 1'b0;
        end else begin
            if (rx_state && scl_rise) begin
                shreg  <= {shreg[DW-2:0], sda_s};
                bitcnt <= bitcnt + 1'b1;
            end
            if (ack_state && scl_rise) begin
                ack_rise <= 1'b1;
                m_ack    <= ~sda_s;
            end
            if (state_q == ST_RD_BYTE) begin
                if (scl_rise) bitcnt <= bitcnt + 1'b1;
                if (scl_fall) shreg  <= {shreg[DW-2:0], 1'b0};
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe = 1'b0;
        mem_we = 1'b0;
        unique case (state_q)
            ST_DEV_ACK, ST_WADDR_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RD_BYTE:   sda_oe = ~shreg[DW-1];
            ST_WAIT_STOP: mem_we = stop_det & wr_pend;
            default:      sda_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/eep_chk.sv
module eep_chk
    import eep_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe,
    input logic       mem_we,
    input logic       tmr_busy,
    input eep_state_e state_q
);
    AST_SDA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i) && $past(scl_i, 2) && $past(scl_i, 3) && $past(scl_i, 4))
        |-> $stable(sda_oe)) else $error("sda_oe moved while SCL high"); // R8

    AST_BUSY_DEAF: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_busy |-> !sda_oe) else $error("drive during programming"); // R6

    AST_WR_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> tmr_busy) else $error("commit without busy window"); // R3

    AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_STOP) |-> !sda_oe) else $error("drive while waiting for STOP"); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !sda_oe) else $error("drive while idle"); // R2
endmodule

bind i2c_eeprom_target eep_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
    .mem_we(mem_we), .tmr_busy(tmr_busy), .state_q(state_q)
);

// File: tb/test_i2c_eeprom_target.sv
module test_i2c_eeprom_target;
    localparam int BUSY = 1000;
    localparam int Q    = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    logic sda_bus;
    int   total = 0;
    int   bad = 0;
    bit   finished = 1'b0;
    logic [7:0] exp_mem [256];
    logic [7:0] exp_ptr = 8'h00;

    always #4 clk = ~clk;
    assign sda_bus = m_sda & ~sda_oe;

    i2c_eeprom_target #(.BUSY_CYCLES(BUSY)) i_i2c_eeprom_target (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe)
    );

    function automatic logic [7:0] dev_byte(input logic rw);
        return {4'b1010, 3'b000, rw};
    endfunction

    task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bit_io(input logic b, output logic r_mid, output logic r_late);
        wait_q(); m_sda = b;
        wait_q(); m_scl = 1'b1;
        wait_q(); r_mid = sda_bus;
        repeat (Q - 1) @(negedge clk); r_late = sda_bus;
        @(negedge clk); m_scl = 1'b0;
    endtask

    task automatic i2c_start();
        wait_q(); m_sda = 1'b1;
        wait_q(); m_scl = 1'b1;
        wait_q(); m_sda = 1'b0;
        wait_q(); m_scl = 1'b0;
    endtask

    task automatic i2c_stop();
        wait_q(); m_sda = 1'b0;
        wait_q(); m_scl = 1'b1;
        wait_q(); m_sda = 1'b1;
        wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic r, r2;
        for (int i = 7; i >= 0; i--) bit_io(b[i], r, r2);
        bit_io(1'b1, r, r2);
        ack = ~r;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        logic [7:0] late;
        logic r, r2;
        for (int i = 7; i >= 0; i--) begin
            bit_io(1'b1, r, r2);
            d[i] = r; late[i] = r2;
        end
        chk("R8 data stable while SCL high", late, d);
        bit_io(~give_ack, r, r2);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        logic ack;
        i2c_start();
        send_byte(dev_byte(1'b0), ack); chk("R2 write address ack", ack, 1);
        send_byte(a, ack);              chk("R3 word address ack", ack, 1);
        send_byte(d, ack);              chk("R3 data ack", ack, 1);
        i2c_stop();
        exp_mem[a] = d;
        exp_ptr = a;
    endtask

    task automatic rand_read(input logic [7:0] a, input int n);
        logic ack;
        logic [7:0] d;
        i2c_start();
        send_byte(dev_byte(1'b0), ack); chk("R2 address ack", ack, 1);
        send_byte(a, ack);              chk("R4 word address ack", ack, 1);
        i2c_start();
        send_byte(dev_byte(1'b1), ack); chk("R4 read address ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, d);
            chk("R4 read data", d, exp_mem[8'(a + i)]);
        end
        i2c_stop();
        exp_ptr = 8'(a + n);
    endtask

    initial begin
        logic ack;
        logic [7:0] d, a;
        void'($urandom(32'd7321));
        for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 sda released after reset", {7'b0, sda_oe}, 8'h00);

        // R1: pointer at 0, array cleared
        i2c_start();
        send_byte(dev_byte(1'b1), ack); chk("R1 read address ack", ack, 1);
        recv_byte(1'b1, d); chk("R1 byte 0 after reset", d, 8'h00);
        recv_byte(1'b0, d); chk("R1 byte 1 after reset", d, 8'h00);
        i2c_stop();
        exp_ptr = 8'h02;

        // R2: wrong configuration bits and wrong family nibble
        i2c_start();
        send_byte(8'b1010_0010, ack); chk("R2 wrong cfg nack", ack, 0);
        send_byte(8'h5A, ack);        chk("R2 ignored after mismatch", ack, 0);
        i2c_stop();
        i2c_start();
        send_byte(8'b1011_0000, ack); chk("R2 wrong family nack", ack, 0);
        i2c_stop();

        // R3 + R6: random writes, each followed by a busy probe
        for (int k = 0; k < 10; k++) begin
            a = 8'($urandom_range(0, 255));
            d = 8'($urandom_range(0, 255));
            do_write(a, d);
            i2c_start();
            send_byte(dev_byte(k[0]), ack); chk("R6 nack while programming", ack, 0);
            i2c_stop();
            repeat (BUSY + 50) @(negedge clk);
        end

        // boundary addresses for the wrap
        do_write(8'hFF, 8'hA5);
        repeat (BUSY + 50) @(negedge clk);
        do_write(8'h00, 8'h3C);
        repeat (BUSY + 50) @(negedge clk);

        // R4 + R5: wrap, NACK, then ignored clocks, then current-address read
        i2c_start();
        send_byte(dev_byte(1'b0), ack); chk("R6 ack after window", ack, 1);
        send_byte(8'hFE, ack);
        i2c_start();
        send_byte(dev_byte(1'b1), ack);
        recv_byte(1'b1, d); chk("R4 byte at FE", d, exp_mem[8'hFE]);
        recv_byte(1'b1, d); chk("R4 byte at FF", d, 8'hA5);
        recv_byte(1'b1, d); chk("R4 wrapped to 00", d, 8'h3C);
        recv_byte(1'b0, d); chk("R4 byte at 01", d, exp_mem[8'h01]);
        recv_byte(1'b0, d); chk("R5 released after nack", d, 8'hFF);
        i2c_stop();
        i2c_start();
        send_byte(dev_byte(1'b1), ack); chk("R4 current read ack", ack, 1);
        recv_byte(1'b0, d); chk("R4 current read continues", d, exp_mem[8'h02]);
        i2c_stop();

        // R7: address-only write sets pointer, no busy window
        a = 8'($urandom_range(0, 255));
        i2c_start();
        send_byte(dev_byte(1'b0), ack);
        send_byte(a, ack); chk("R7 address-only ack", ack, 1);
        i2c_stop();
        i2c_start();
        send_byte(dev_byte(1'b1), ack); chk("R7 no busy after address-only", ack, 1);
        recv_byte(1'b0, d); chk("R7 pointer set", d, exp_mem[a]);
        i2c_stop();

        // R4: random reads of random length
        for (int k = 0; k < 8; k++) begin
            rand_read(8'($urandom_range(0, 255)), $urandom_range(1, 4));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule